// File: doc/BRIEF.md
# Programmable AND-OR Product Term Array

This block is the logic core of a small programmable logic device. It takes eight dedicated input signals and eight feedback signals and drives each one onto two array lines, true and inverted, for thirty-two lines in all. A stored connection map states which of those lines feed each of sixty-four product terms. Every term is the AND of the lines connected to it.

The terms are split into eight cells of eight terms each. In every cell, seven terms always feed that cell's OR sum. The eighth, extra term is brought out on its own. A per-cell join control can also fold it into the sum, so the consuming output cell may use it either as an output enable or as one more sum term.

The map is loaded one 32-bit row per clock through a write port. An erase input opens every connection in one cycle. All outputs are combinational from the inputs and the stored map.

Top module: `sop_term_array`

## Requirements
- R1: Array signal k drives line 2k true and line 2k+1 inverted. Signals 0 to 7 are `ded_in[0..7]` and signals 8 to 15 are `fb_in[0..7]`.
- R2: A product term is the AND of the lines whose map bits are 1 in its row. Bit j of row r connects line j to term r.
- R3: A term whose row holds no set bit evaluates to 1 for every input.
- R4: A term connected to both lines of one signal evaluates to 0 for every input.
- R5: Rows 8c to 8c+6 are the sum terms of cell c. Row 8c+7 is the extra term of cell c and appears on `aux_term[c]`.
- R6: `or_sum[c]` is the OR of the seven sum terms of cell c. When `aux_join[c]` is 1, the extra term of cell c is ORed in as well.
- R7: While `map_we` is 1, the rising clock edge stores `map_row` into row `map_addr`, and all other rows keep their contents.
- R8: When `erase` is 1, the rising clock edge clears every map bit. This takes precedence over a write in the same cycle.
- R9: Reset clears the map, so after reset every output bit is 1.
- R10: Outputs follow input changes combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for map writes and erase |
| rst_n | input | 1 | Active-low asynchronous reset; clears the map |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or I/O pin signals |
| aux_join | input | 8 | Per cell: 1 folds the extra term into the OR sum |
| map_we | input | 1 | Row write enable |
| map_addr | input | 6 | Row (product term) index to write |
| map_row | input | 32 | Connection bits for the addressed row |
| erase | input | 1 | Clears the whole map at the clock edge |
| or_sum | output | 8 | Per-cell OR of product terms |
| aux_term | output | 8 | Per-cell extra product term |

## Verification
The hardest situation to reach is a single term changing an OR sum. Every unprogrammed term is constantly true, so one term on its own can never be seen at an output. Each scenario first writes self-conflicting rows into the other six sum terms of the cell, forcing them to 0. It then steers the remaining term through all of its input combinations and compares every output with a bench model built from its own copy of the written rows. The same method separates the extra term from the sum, by toggling the join control while the sum terms are held at 0.

// File: rtl/sop_pkg.sv
package sop_pkg;
   typedef enum logic [1:0] {
      MAP_HOLD  = 2'd0,
      MAP_WRITE = 2'd1,
      MAP_CLEAR = 2'd2
   } map_op_e;

   localparam int unsigned DEF_DED_SIGS = 8;
   localparam int unsigned DEF_FB_SIGS  = 8;
   localparam int unsigned DEF_CELLS    = 8;
   localparam int unsigned DEF_SUM_PTS  = 7;
endpackage

// File: rtl/sop_fuse_map.sv
module sop_fuse_map
   import sop_pkg::*;
#(
   parameter int unsigned N_ROWS = 64,
   parameter int unsigned ROW_W  = 32,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [ROW_W-1:0]         row,
   input  logic                     clear,
   output logic [N_ROWS*ROW_W-1:0]  map_flat
);
   logic [ROW_W-1:0] rows_q [N_ROWS];
   map_op_e op;

   always_comb begin
      if (clear)                               op = MAP_CLEAR;
      else if (we && (int'(addr) < N_ROWS))    op = MAP_WRITE;
      else                                     op = MAP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < N_ROWS; r++) rows_q[r] <= '0;
      end else begin
         case (op)
            MAP_CLEAR: for (int r = 0; r < N_ROWS; r++) rows_q[r] <= '0;
            MAP_WRITE: rows_q[addr] <= row;
            default: ;
         endcase
      end
   end

   for (genvar r = 0; r < N_ROWS; r++) begin : g_flat
      assign map_flat[r*ROW_W +: ROW_W] = rows_q[r];
   end

   // R8
   erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (map_flat == '0));

   // R7
   row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clear && (int'(addr) < N_ROWS)) |=> (rows_q[$past(addr)] == $past(row)));
endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
   parameter int unsigned N_LINES = 32
) (
   input  logic [N_LINES-1:0] lines,
   input  logic [N_LINES-1:0] conn,
   output logic               term
);
   // an open connection contributes a constant 1 to the AND
   assign term = &(lines | ~conn);
endmodule

// File: rtl/sop_or_cell.sv
module sop_or_cell #(
   parameter int unsigned N_SUM   = 7,
   parameter bit          JOIN_EN = 1'b1
) (
   input  logic [N_SUM-1:0] sum_terms,
   input  logic             aux,
   input  logic             join_aux,
   output logic             sum
);
   if (JOIN_EN) begin : g_join
      assign sum = (|sum_terms) | (aux & join_aux);
   end else begin : g_nojoin
      logic unused_join;
      assign unused_join = aux ^ join_aux;
      assign sum = |sum_terms;
   end
endmodule

// File: rtl/sop_term_array.sv
module sop_term_array
   import sop_pkg::*;
#(
   parameter int unsigned N_DED   = DEF_DED_SIGS,
   parameter int unsigned N_FB    = DEF_FB_SIGS,
   parameter int unsigned N_CELL  = DEF_CELLS,
   parameter int unsigned N_SUM   = DEF_SUM_PTS,
   parameter bit          JOIN_EN = 1'b1,
   localparam int unsigned N_SIG   = N_DED + N_FB,
   localparam int unsigned N_LINES = 2 * N_SIG,
   localparam int unsigned PER_CELL = N_SUM + 1,
   localparam int unsigned N_TERMS = N_CELL * PER_CELL,
   localparam int unsigned ADDR_W  = (N_TERMS > 1) ? $clog2(N_TERMS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_DED-1:0]    ded_in,
   input  logic [N_FB-1:0]     fb_in,
   input  logic [N_CELL-1:0]   aux_join,
   input  logic                map_we,
   input  logic [ADDR_W-1:0]   map_addr,
   input  logic [N_LINES-1:0]  map_row,
   input  logic                erase,
   output logic [N_CELL-1:0]   or_sum,
   output logic [N_CELL-1:0]   aux_term
);
   if (N_DED < 1) begin : g_bad_ded
      $error("sop_term_array: N_DED must be at least 1");
   end
   if (N_FB < 1) begin : g_bad_fb
      $error("sop_term_array: N_FB must be at least 1");
   end
   if (N_CELL < 1 || N_SUM < 1) begin : g_bad_cell
      $error("sop_term_array: N_CELL and N_SUM must be at least 1");
   end

   logic [N_SIG-1:0]          sig;
   logic [N_LINES-1:0]        lines;
   logic [N_TERMS*N_LINES-1:0] map_flat;
   logic [N_TERMS-1:0]        terms;

   assign sig = {fb_in, ded_in};

   for (genvar k = 0; k < N_SIG; k++) begin : g_line
      assign lines[2*k]   = sig[k];
      assign lines[2*k+1] = ~sig[k];
   end

   sop_fuse_map #(
      .N_ROWS (N_TERMS),
      .ROW_W  (N_LINES),
      .ADDR_W (ADDR_W)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (map_we),
      .addr     (map_addr),
      .row      (map_row),
      .clear    (erase),
      .map_flat (map_flat)
   );

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      sop_pterm #(.N_LINES(N_LINES)) u_pt (
         .lines (lines),
         .conn  (map_flat[t*N_LINES +: N_LINES]),
         .term  (terms[t])
      );
   end

   for (genvar c = 0; c < N_CELL; c++) begin : g_cell
      sop_or_cell #(.N_SUM(N_SUM), .JOIN_EN(JOIN_EN)) u_or (
         .sum_terms (terms[c*PER_CELL +: N_SUM]),
         .aux       (terms[c*PER_CELL + N_SUM]),
         .join_aux  (aux_join[c]),
         .sum       (or_sum[c])
      );
      assign aux_term[c] = terms[c*PER_CELL + N_SUM];

      // R6
      dead_sum_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((terms[c*PER_CELL +: N_SUM] == '0) && !(aux_join[c] && aux_term[c])) |-> !or_sum[c]);
   end

   function automatic logic row_conflict(input logic [N_LINES-1:0] r);
      logic hit;
      hit = 1'b0;
      for (int k = 0; k < N_SIG; k++) hit = hit | (r[2*k] & r[2*k+1]);
      return hit;
   endfunction

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term_chk
      // R3
      open_term_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (map_flat[t*N_LINES +: N_LINES] == '0) |-> terms[t]);
      // R4
      conflict_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
         row_conflict(map_flat[t*N_LINES +: N_LINES]) |-> !terms[t]);
   end
endmodule

// File: tb/tb_sop_term_array.sv
module tb_sop_term_array;
   localparam int NT = 64;
   localparam int NL = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ded_in = '0;
   logic [7:0]  fb_in = '0;
   logic [7:0]  aux_join = '0;
   logic        map_we = 1'b0;
   logic [5:0]  map_addr = '0;
   logic [31:0] map_row = '0;
   logic        erase = 1'b0;
   logic [7:0]  or_sum;
   logic [7:0]  aux_term;

   int errors = 0;
   int checks = 0;
   logic [NL-1:0] shadow [NT];

   always #5 clk = ~clk;

   sop_term_array dut (
      .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
      .aux_join(aux_join), .map_we(map_we), .map_addr(map_addr),
      .map_row(map_row), .erase(erase), .or_sum(or_sum), .aux_term(aux_term)
   );

   localparam logic [31:0] CONFLICT = 32'h0000_0003;

   function automatic logic [31:0] pin(input int s, input int inv);
      return 32'h1 << (2*s + inv);
   endfunction

   function automatic logic model_term(input int t);
      logic v;
      logic lv;
      v = 1'b1;
      for (int j = 0; j < NL; j++) begin
         if (j/2 < 8) lv = ded_in[j/2]; else lv = fb_in[j/2-8];
         if (j % 2 == 1) lv = !lv;
         if (shadow[t][j] && !lv) v = 1'b0;
      end
      return v;
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_model(input string tag);
      logic [7:0] es, ea;
      for (int c = 0; c < 8; c++) begin
         logic s;
         s = 1'b0;
         for (int i = 0; i < 7; i++) s = s | model_term(c*8+i);
         ea[c] = model_term(c*8+7);
         es[c] = s | (ea[c] & aux_join[c]);
      end
      #1;
      check({tag, " or_sum"}, or_sum, es);
      check({tag, " aux_term"}, aux_term, ea);
   endtask

   task automatic write_row(input int a, input logic [31:0] r);
      @(negedge clk);
      map_we = 1'b1; map_addr = 6'(a); map_row = r;
      @(negedge clk);
      map_we = 1'b0;
      shadow[a] = r;
   endtask

   task automatic kill_sums(input int c);
      for (int i = 0; i < 7; i++) write_row(c*8+i, CONFLICT);
   endtask

   task automatic t_reset;
      #1;
      check("R9 reset or_sum", or_sum, 8'hFF);
      check("R3 reset aux_term", aux_term, 8'hFF);
   endtask

   task automatic t_single;
      kill_sums(0);
      write_row(0, pin(0, 0));
      write_row(7, CONFLICT);
      ded_in[0] = 1'b1; #1;
      check("R2 R5 cell0 follows ded0=1", {7'b0, or_sum[0]}, 8'h01);
      ded_in[0] = 1'b0; #1;
      check("R10 cell0 follows ded0=0 without clock", {7'b0, or_sum[0]}, 8'h00);
      check("R5 cell0 aux conflict", {7'b0, aux_term[0]}, 8'h00);
      check_model("R1 single");
   endtask

   task automatic t_feedback;
      kill_sums(1);
      write_row(8, pin(1, 0) | pin(11, 1));
      write_row(15, CONFLICT);
      for (int v = 0; v < 4; v++) begin
         ded_in[1] = v[0]; fb_in[3] = v[1]; #1;
         check("R1 R2 ded1 and not fb3", {7'b0, or_sum[1]}, {7'b0, (v == 1)});
         check_model("R2 feedback");
      end
   endtask

   task automatic t_conflict;
      kill_sums(2);
      write_row(16, pin(10, 0) | pin(10, 1));
      write_row(23, pin(10, 0) | pin(10, 1) | pin(3, 0));
      for (int v = 0; v < 2; v++) begin
         fb_in[2] = v[0]; ded_in[3] = 1'b1; #1;
         check("R4 conflict sum", {7'b0, or_sum[2]}, 8'h00);
         check("R4 conflict aux", {7'b0, aux_term[2]}, 8'h00);
      end
   endtask

   task automatic t_aux;
      kill_sums(3);
      write_row(31, pin(4, 0));
      for (int v = 0; v < 4; v++) begin
         ded_in[4] = v[0]; aux_join[3] = v[1]; #1;
         check("R5 aux follows ded4", {7'b0, aux_term[3]}, {7'b0, v[0]});
         check("R6 join gates aux into sum", {7'b0, or_sum[3]}, {7'b0, v[0] & v[1]});
      end
      aux_join = '0;
      check_model("R6 aux");
   endtask

   task automatic t_rewrite;
      write_row(0, pin(0, 1));
      ded_in[0] = 1'b0; #1;
      check("R7 rewritten row0", {7'b0, or_sum[0]}, 8'h01);
      check_model("R7 others kept");
   endtask

   task automatic t_erase;
      @(negedge clk);
      erase = 1'b1; map_we = 1'b1; map_addr = 6'd40; map_row = CONFLICT;
      @(negedge clk);
      erase = 1'b0; map_we = 1'b0;
      for (int r = 0; r < NT; r++) shadow[r] = '0;
      #1;
      check("R8 erase wins, or_sum", or_sum, 8'hFF);
      check("R8 erase wins, aux_term", aux_term, 8'hFF);
      check_model("R8 after erase");
   endtask

   initial begin
      for (int r = 0; r < NT; r++) shadow[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_feedback();
      t_conflict();
      t_aux();
      t_rewrite();
      t_erase();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule